// File: doc/BRIEF.md
# Station-Management Master for Ethernet PHYs

This block runs management frames towards external PHY devices on a two-wire serial bus: a clock line (MDC) and a bidirectional data line (MDIO). A host controls it through two 16-bit registers. One is a combined command/status word and the other is a data word. To read a PHY register, the host writes the command word with the write-select bit clear. It then polls the done bit in that same word and collects the returned value from the data word. To write a PHY register, the host first loads the data word and then writes the command word with the write-select bit set.

Each frame is 64 MDC periods long, sent most significant bit first. It starts with 32 ones. Next come the start pair `01` and the opcode (`10` for a read, `01` for a write). Then come the 5-bit PHY address, the 5-bit register number, a 2-bit turnaround and 16 data bits. The master changes MDIO while MDC is low. It samples returned data on the rising MDC edge. MDC runs only while a frame is in progress.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the command word reads `16'h8000`: done is 1 and all fields are 0. The data word reads 0, MDC is low and the MDIO output enable is low.
- R2: Command word layout: bits 4:0 hold the register number, bits 12:8 the PHY address, and bit 13 selects a write (1) or a read (0). Bit 15 reads back as the done flag. All other bits read 0.
- R3: Writing the command word while idle starts a frame. Done reads 0 in the very next clock cycle.
- R4: The master-driven part of every frame is 32 ones, `01`, then the opcode (`10` for a read, `01` for a write), the PHY address and the register number, all MSB first. A write frame continues with turnaround `10` and the 16 data bits, and drives MDIO (output enable high) for the whole frame.
- R5: The data bits of a write frame equal the data word as it stood when the command word was written.
- R6: In a read frame the master releases MDIO (output enable low) from the first turnaround bit to the end of the frame. It samples the 16 data bits on rising MDC edges. When done returns to 1, the data word holds the value the PHY returned.
- R7: MDC has a period of `CLK_DIV` system clocks, with each phase lasting `CLK_DIV/2` clocks. MDC stays low while no frame is in progress.
- R8: A command-word write while a frame is in progress is ignored. The command word reads back unchanged, and the frame in flight and its length are unaffected.
- R9: A data-word write while a frame is in progress is ignored. Neither the data word nor the frame in flight changes.
- R10: Done stays 0 for exactly `64*CLK_DIV` system clock cycles per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 1 | Register select: 0 command word, 1 data word |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read-back of the register chosen by host_sel |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable; low releases the line |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
The hardest situation to reach is a host write that lands in the middle of a frame. This covers both a second command and an overwrite of the data word, and it must leave the bus traffic, the frame length and the registers untouched. The driver counts clock cycles after a command is accepted. About a hundred cycles into a frame it issues a conflicting command write and then a data write. The scoreboard then compares the bits a PHY model captured against the original transaction, and the bench re-times the busy interval. Read data comes back through the PHY model, which drives the line only after the master releases it. This proves both the release and the sampling edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 5;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int TA_POS    = PRE_LEN + 4 + 2 * ADDR_W;
    localparam int DATA_POS  = TA_POS + 2;

    // command word bit positions (host-visible)
    localparam int CW_DONE  = 15;
    localparam int CW_WRITE = 13;
    localparam int CW_PHY_L = 8;
    localparam int CW_REG_L = 0;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } mgmt_op_e;

    typedef struct packed {
        mgmt_op_e          op;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regn;
    } mgmt_cmd_t;

    function automatic mgmt_cmd_t decode_cmd(input logic [DATA_W-1:0] w);
        mgmt_cmd_t c;
        c.op   = mgmt_op_e'(w[CW_WRITE]);
        c.phy  = w[CW_PHY_L +: ADDR_W];
        c.regn = w[CW_REG_L +: ADDR_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] encode_cmd(input mgmt_cmd_t c, input logic done);
        logic [DATA_W-1:0] w;
        w                      = '0;
        w[CW_DONE]             = done;
        w[CW_WRITE]            = c.op;
        w[CW_PHY_L +: ADDR_W]  = c.phy;
        w[CW_REG_L +: ADDR_W]  = c.regn;
        return w;
    endfunction

    function automatic logic [FRAME_LEN-1:0] build_frame(input mgmt_cmd_t c,
                                                         input logic [DATA_W-1:0] wdata);
        logic [1:0] opc;
        opc = (c.op == OP_WRITE) ? 2'b01 : 2'b10;
        return {{PRE_LEN{1'b1}}, 2'b01, opc, c.phy, c.regn, 2'b10, wdata};
    endfunction

endpackage

// File: rtl/mdc_pacer.sv
module mdc_pacer #(
    parameter int CLK_DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int HALF = (CLK_DIV / 2 < 1) ? 1 : CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          wrap;

    assign wrap = run && (cnt_q == LAST);
    assign rise = wrap && !mdc_q;
    assign fall = wrap && mdc_q;
    assign mdc  = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mgmt_cmd_t         cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_POS);

    logic                 busy_q;
    mgmt_op_e             op_q;
    logic [IDX_W-1:0]     idx_q;
    logic [FRAME_LEN-1:0] sh_q;
    logic [DATA_W-1:0]    rx_q;
    logic                 is_rd;
    logic                 last_fall;

    assign is_rd     = (op_q == OP_READ);
    assign last_fall = busy_q && fall && (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            op_q   <= OP_READ;
            idx_q  <= '0;
            sh_q   <= '1;
            rx_q   <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                op_q   <= cmd.op;
                idx_q  <= '0;
                sh_q   <= build_frame(cmd, wdata);
            end
        end else begin
            if (rise && is_rd && (idx_q >= DAT_IDX))
                rx_q <= {rx_q[DATA_W-2:0], mdio_i};
            if (fall) begin
                if (idx_q == LAST_IDX) begin
                    busy_q <= 1'b0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                    sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b1};
                end
            end
        end
    end

    assign busy     = busy_q;
    assign mdio_o   = busy_q ? sh_q[FRAME_LEN-1] : 1'b1;
    assign mdio_oe  = busy_q && !(is_rd && (idx_q >= TA_IDX));
    assign rd_valid = last_fall && is_rd;
    assign rd_data  = rx_q;

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 50
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic        host_sel,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mgmt_cmd_t         cmd_q;
    logic [DATA_W-1:0] data_q;
    logic              busy;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              rise;
    logic              fall;
    logic              accept_cmd;
    logic              accept_data;
    mgmt_cmd_t         new_cmd;

    assign new_cmd     = decode_cmd(host_wdata);
    assign accept_cmd  = host_we && !host_sel && !busy;
    assign accept_data = host_we &&  host_sel && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (accept_cmd)
                cmd_q <= new_cmd;
            if (rd_valid)
                data_q <= rd_data;
            else if (accept_data)
                data_q <= host_wdata;
        end
    end

    assign host_rdata = host_sel ? data_q : encode_cmd(cmd_q, !busy);

    mdc_pacer #(.CLK_DIV(CLK_DIV)) u_pacer (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_frame_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .start    (accept_cmd),
        .cmd      (new_cmd),
        .wdata    (data_q),
        .rise     (rise),
        .fall     (fall),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // R3
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        accept_cmd |=> busy);

    // R8
    busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (host_we && !host_sel && busy) |=> $stable(cmd_q));

    // R9
    busy_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !rd_valid) |=> $stable(data_q));

    // R7
    idle_mdc_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    // R6
    read_release_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !mdio_oe);

    // R4
    write_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_q.op == OP_WRITE) |-> mdio_oe);

endmodule

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
    localparam int DIV   = 8;
    localparam int FRAME = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mdio_mgmt_master #(.CLK_DIV(DIV)) u_mdio_mgmt_master (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // ---------------- PHY model and frame scoreboard ----------------
    logic [63:0] exp_q[$];
    logic [63:0] mask_q[$];
    logic [15:0] phy_mem [32];
    logic [63:0] cap = '0;
    logic [15:0] rd_word = '0;
    bit          cap_is_read = 0;
    int          phy_cnt = 0;
    int          oe_err = 0;
    int          frm_cnt = 0;
    int          frm_fail = 0;

    initial for (int i = 0; i < 32; i++) phy_mem[i] = 16'h3C00 ^ (16'(i) * 16'h0111);

    always @(posedge mdc) begin
        logic b;
        logic [63:0] e, m;
        b = mdio_oe ? mdio_o : 1'b0;
        if (phy_cnt >= 46 && cap_is_read && mdio_oe) oe_err++;
        cap = {cap[62:0], b};
        if (phy_cnt == 35) cap_is_read = (cap[1:0] == 2'b10);
        phy_cnt++;
        if (phy_cnt == FRAME) begin
            frm_cnt++;
            if (exp_q.size() == 0) begin
                frm_fail++;
                $display("FAIL R4 unexpected frame act=%h exp=none", cap);
            end else begin
                e = exp_q.pop_front();
                m = mask_q.pop_front();
                if (((cap ^ e) & m) != 64'd0) begin
                    frm_fail++;
                    $display("FAIL R4/R5 frame act=%h exp=%h", cap & m, e & m);
                end
            end
            if (!cap_is_read) phy_mem[cap[22:18]] = cap[15:0];
            phy_cnt = 0;
        end
    end

    always @(negedge mdc) begin
        if (cap_is_read && phy_cnt >= 46) begin
            if (phy_cnt == 46) begin
                rd_word = phy_mem[cap[4:0]];
                mdio_i  = 1'b1;
            end else if (phy_cnt == 47) begin
                mdio_i = 1'b0;
            end else begin
                mdio_i = rd_word[63 - phy_cnt];
            end
        end else begin
            mdio_i = 1'b1;
        end
    end

    // MDC phase monitor (R7)
    int   gap = 0;
    int   pace_err = 0;
    logic mdc_prev = 1'b0;
    always @(negedge clk) begin
        if (mdc !== mdc_prev) begin
            if (!mdc && gap != DIV / 2) pace_err++;
            gap = 1;
        end else begin
            gap++;
        end
        mdc_prev = mdc;
    end

    // ---------------- host driver ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0; host_sel = 1'b0;
    endtask

    task automatic host_read(input logic sel, output logic [15:0] d);
        host_sel = sel;
        #1 d = host_rdata;
        host_sel = 1'b0;
    endtask

    function automatic logic [15:0] cw(input bit wr, input logic [4:0] p, input logic [4:0] r);
        return {2'b00, wr, p, 3'b000, r};
    endfunction

    // One transaction; optional mid-frame interference.
    task automatic txn(input bit wr, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] wd, input bit poke, input logic [15:0] rd_exp);
        logic [15:0] v;
        int n;
        if (wr) host_write(1'b1, wd);
        exp_q.push_back({32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r,
                         (wr ? {2'b10, wd} : 18'd0)});
        mask_q.push_back(wr ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, 18'd0});
        host_write(1'b0, cw(wr, p, r));
        // R3: done low right after the command, fields read back (R2)
        host_read(1'b0, v);
        chk("R2/R3 cmd readback busy", 32'(v), 32'(cw(wr, p, r)));
        n = 0;
        while (1) begin
            if (poke && n == 100) begin
                host_we = 1'b1; host_sel = 1'b0; host_wdata = cw(!wr, ~p, ~r);
                @(negedge clk); n++;
                host_we = 1'b0;
                host_read(1'b0, v);
                chk("R8 cmd write while busy ignored", 32'(v), 32'(cw(wr, p, r)));
                host_we = 1'b1; host_sel = 1'b1; host_wdata = ~wd ^ 16'h0F0F;
                @(negedge clk); n++;
                host_we = 1'b0; host_sel = 1'b0;
            end
            host_read(1'b0, v);
            if (v[15]) break;
            @(negedge clk); n++;
            if (n > 4 * FRAME * DIV) break;
        end
        chk("R10 busy length", 32'(n), 32'(FRAME * DIV));
        host_read(1'b0, v);
        chk("R2 cmd readback done", 32'(v), 32'(cw(wr, p, r) | 16'h8000));
        chk("R7 mdc low when idle", 32'(mdc), 32'd0);
        host_read(1'b1, v);
        if (wr) chk("R9 data word after write frame", 32'(v), 32'(wd));
        else    chk("R6 read data latched", 32'(v), 32'(rd_exp));
    endtask

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        host_read(1'b0, v);
        chk("R1 cmd word after reset", 32'(v), 32'h8000);
        host_read(1'b1, v);
        chk("R1 data word after reset", 32'(v), 32'h0000);
        chk("R1 mdc after reset", 32'(mdc), 32'd0);
        chk("R1 oe after reset", 32'(mdio_oe), 32'd0);

        // write then read back through the PHY model (R4, R5, R6)
        txn(1'b1, 5'h11, 5'h0A, 16'hA5C3, 1'b0, 16'h0);
        txn(1'b0, 5'h11, 5'h0A, 16'h0, 1'b0, 16'hA5C3);
        // field extremes
        txn(1'b1, 5'h00, 5'h00, 16'h0000, 1'b0, 16'h0);
        txn(1'b1, 5'h1F, 5'h1F, 16'hFFFF, 1'b0, 16'h0);
        txn(1'b0, 5'h1F, 5'h1F, 16'h0, 1'b0, 16'hFFFF);
        txn(1'b0, 5'h00, 5'h00, 16'h0, 1'b0, 16'h0000);
        // preloaded register, with interference during a read (R8)
        txn(1'b0, 5'h05, 5'h07, 16'h0, 1'b1, 16'h3C00 ^ (16'h7 * 16'h0111));
        // interference during a write: data write ignored (R8, R9)
        txn(1'b1, 5'h0A, 5'h15, 16'h5A5A, 1'b1, 16'h0);
        txn(1'b0, 5'h0A, 5'h15, 16'h0, 1'b0, 16'h5A5A);

        repeat (4) @(negedge clk);
        chk("R6 mdio released in read data phase", 32'(oe_err), 32'd0);
        chk("R7 mdc phase length", 32'(pace_err), 32'd0);
        chk("R4 frames seen", 32'(frm_cnt), 32'd9);
        chk("R4/R5 frame mismatches", 32'(frm_fail), 32'd0);
        chk("R4 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
        $finish;
    end

endmodule